// File: doc/BRIEF.md
# Multiplexed pseudo-SRAM bus decoder

This block is the device-side front end of a 16-bit pseudo-SRAM whose address and data travel on one shared bus. On every rising edge of its clock it samples the chip enable, address-valid strobe, output enable, write enable, configuration-register select and the two byte-lane selects. From these it decides what kind of bus cycle is taking place and reports that as a cycle code one clock later. The decision is shaped by the mode bit of the bus configuration register, by the register-select pin and by the address-valid strobe together.

It holds two configuration words: a bus configuration word (operating mode, WAIT polarity) and a refresh configuration word (deep power-down arm bit). It reads and writes a small internal word array, which stands in for the memory core. It drives registered output enables for each byte lane of the data bus, and it drives the WAIT pin with its own enable. In burst mode, accesses start with an address phase, and subsequent words go to auto-incremented addresses. A chip-enable release after the arm bit has been cleared parks the block in deep power-down. Deep power-down wipes the array's contents and restores both configuration words on exit.

Top module: `mux_psram_fe`

## Requirements
- R1: After reset the bus configuration word is 16'h8400 (bit 15 = 1: asynchronous mode; bit 10 = 1: WAIT active high), the refresh word is 16'h0010, `cycle` is 0, `dpd` is 0 and every output enable is low.
- R2: Each sampled cycle is reported on `cycle` one clock later: 0 standby, 1 no-op, 2 array read, 3 array write, 4 burst-read start, 5 burst-write start, 6 burst continue, 7 configuration write, 8 configuration read, 9 deep power-down, 10 address latch.
- R3: In asynchronous mode, a cycle with `adv_n` low latches `dq_in[ADDR_W-1:0]` as the address. A cycle with `we_n` low stores `dq_in` at that address. A cycle with `oe_n` low (and `we_n` high) presents the stored word on `dq_out` one clock later.
- R4: `lb_n` low enables `dq_oe_lo` and the write of bits 7:0. `ub_n` low enables `dq_oe_hi` and the write of bits 15:8. A byte whose lane is high is neither driven nor written.
- R5: With `cre` high outside a burst, the target is chosen by bit 0 of the latched address (0 refresh word, 1 bus configuration word). `we_n` low with `oe_n` high writes `dq_in` to the target. `oe_n` low with `we_n` high drives the target onto `dq_out`.
- R6: When bus configuration bit 15 is 0 (burst mode), `adv_n` low with `ce_n` low starts a burst from address `dq_in`: a read if `we_n` is high, a write if it is low. Each following `adv_n`-high cycle is a burst continue that moves one word and then adds one to the address.
- R7: In burst mode, a cycle with `adv_n` low and `cre` high is the first cycle of a one-word burst: `dq_in[0]` selects the target, the next cycle transfers the word, and the burst then ends.
- R8: `wait_oe` is high after every cycle other than standby and deep power-down. WAIT is at its active level for exactly the cycle after a burst start. Bus configuration bit 10 sets the active level (1 high, 0 low).
- R9: A cycle with `ce_n` high ends any burst, turns all output enables off one clock later, and neither writes the array nor changes the address.
- R10: A no-op cycle (`ce_n` low, `cre` low, `adv_n` high, `oe_n` and `we_n` high, no burst running) drives nothing and changes no stored state.
- R11: If refresh bit 4 is 0, a `ce_n` rise enters deep power-down (`dpd` = 1). While in deep power-down, all inputs are ignored and the outputs stay off. The next `ce_n` fall leaves deep power-down, restores both configuration words to their reset values and leaves every array word reading 0. With bit 4 at 1, a `ce_n` rise is plain standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cre | input | 1 | Configuration register select, active high |
| lb_n | input | 1 | Lower byte lane select, active low |
| ub_n | input | 1 | Upper byte lane select, active low |
| dq_in | input | 16 | Shared address/data bus, input side |
| dq_out | output | 16 | Shared bus, output side |
| dq_oe_lo | output | 1 | Drive enable for bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for bits 15:8 |
| wait_o | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT drive enable |
| cycle | output | 4 | Code of the previous sampled cycle |
| dpd | output | 1 | Deep power-down state |

## Verification
The classifier is tested with pin patterns that differ in one pin at a time:
- Address latch against array write, which separates the effect of the strobe from the effect of the write enable.
- Register select against array access at the same enables, which separates configuration traffic from array traffic.
- The same strobe-low pattern before and after the mode bit is cleared, which separates an address latch from a burst start.

Byte-lane patterns of both, lower-only and upper-only show whether each lane is driven and written on its own. Chip-enable releases with the arm bit set and cleared separate plain standby from deep power-down. Reads after the exit show that the array was wiped and both words were restored.

// File: rtl/psram_fe_pkg.sv
`timescale 1ns/1ps
package psram_fe_pkg;

    localparam int DQ_W     = 16;
    localparam int MODE_BIT = 15;  // 1: asynchronous, 0: burst
    localparam int WPOL_BIT = 10;  // WAIT active level
    localparam int ARM_BIT  = 4;   // 0 arms deep power-down

    typedef enum logic [3:0] {
        CT_STANDBY  = 4'd0,
        CT_NOP      = 4'd1,
        CT_READ     = 4'd2,
        CT_WRITE    = 4'd3,
        CT_BRD_INIT = 4'd4,
        CT_BWR_INIT = 4'd5,
        CT_BCONT    = 4'd6,
        CT_CFG_WR   = 4'd7,
        CT_CFG_RD   = 4'd8,
        CT_DPD      = 4'd9,
        CT_ADDR     = 4'd10
    } cyc_e;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RD,
        BS_WR,
        BS_CFG_RD,
        BS_CFG_WR
    } bst_e;

endpackage

// File: rtl/psram_fe_decode.sv
`timescale 1ns/1ps
module psram_fe_decode
    import psram_fe_pkg::*;
(
    input  logic ce_n,
    input  logic adv_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic cre,
    input  logic burst_mode,
    input  logic burst_busy,
    input  logic in_dpd,
    input  logic ce_was_low,
    input  logic dpd_armed,
    output cyc_e cyc
);

    always_comb begin
        if (in_dpd) begin
            cyc = CT_DPD;
        end else if (ce_n) begin
            cyc = (ce_was_low && dpd_armed) ? CT_DPD : CT_STANDBY;
        end else if (burst_mode && !adv_n) begin
            if (cre) begin
                if (!we_n)      cyc = CT_CFG_WR;
                else if (!oe_n) cyc = CT_CFG_RD;
                else            cyc = CT_NOP;
            end else begin
                cyc = we_n ? CT_BRD_INIT : CT_BWR_INIT;
            end
        end else if (burst_mode && burst_busy) begin
            cyc = CT_BCONT;
        end else if (cre) begin
            if (!we_n && oe_n)      cyc = CT_CFG_WR;
            else if (!oe_n && we_n) cyc = CT_CFG_RD;
            else                    cyc = CT_NOP;
        end else if (!adv_n) begin
            cyc = CT_ADDR;
        end else if (!we_n) begin
            cyc = CT_WRITE;
        end else if (!oe_n) begin
            cyc = CT_READ;
        end else begin
            cyc = CT_NOP;
        end
    end

endmodule

// File: rtl/psram_fe_cfg.sv
`timescale 1ns/1ps
module psram_fe_cfg #(
    parameter logic [15:0] BCR_RST = 16'h8400,
    parameter logic [15:0] RCR_RST = 16'h0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        sel,      // 1: bus configuration, 0: refresh
    input  logic [15:0] wdata,
    input  logic        restore,
    output logic [15:0] bcr,
    output logic [15:0] rcr
);

    typedef struct packed {
        logic [15:0] bcr;
        logic [15:0] rcr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (restore) begin
            cfg_d.bcr = BCR_RST;
            cfg_d.rcr = RCR_RST;
        end else if (we) begin
            if (sel) cfg_d.bcr = wdata;
            else     cfg_d.rcr = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.bcr <= BCR_RST;
            cfg_q.rcr <= RCR_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign bcr = cfg_q.bcr;
    assign rcr = cfg_q.rcr;

endmodule

// File: rtl/psram_fe_array.sv
`timescale 1ns/1ps
module psram_fe_array #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        lanes,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [15:0]       wdata,
    input  logic              clr,
    input  logic [ADDR_W-1:0] raddr,
    output logic [15:0]       rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = 2;

    logic [15:0]      mem_q [DEPTH];
    logic [DEPTH-1:0] vld_q, vld_d;

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (lanes[l]) mem_q[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    always_comb begin
        vld_d = vld_q;
        if (clr)                vld_d = '0;
        else if (we && |lanes)  vld_d[waddr] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign rdata = vld_q[raddr] ? mem_q[raddr] : 16'h0000;

endmodule

// File: rtl/mux_psram_fe.sv
`timescale 1ns/1ps
module mux_psram_fe
    import psram_fe_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter logic [15:0] BCR_RST = 16'h8400,
    parameter logic [15:0] RCR_RST = 16'h0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        adv_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        cre,
    input  logic        lb_n,
    input  logic        ub_n,
    input  logic [15:0] dq_in,
    output logic [15:0] dq_out,
    output logic        dq_oe_lo,
    output logic        dq_oe_hi,
    output logic        wait_o,
    output logic        wait_oe,
    output logic [3:0]  cycle,
    output logic        dpd
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        bst_e              bst;
        logic              sel;
        logic              dpd;
        logic              ce_low;
        logic [DQ_W-1:0]   dout;
        logic              oe_lo;
        logic              oe_hi;
        logic              wait_act;
        logic              wait_oe;
        cyc_e              cyc;
    } st_t;

    st_t st_d, st_q;

    cyc_e            cyc;
    logic [DQ_W-1:0] bcr, rcr, arr_rdata;
    logic            burst_mode;
    logic            arr_we, arr_clr, cfg_we, cfg_sel, cfg_restore;

    assign burst_mode = !bcr[MODE_BIT];

    psram_fe_decode u_dec (
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .cre        (cre),
        .burst_mode (burst_mode),
        .burst_busy (st_q.bst != BS_IDLE),
        .in_dpd     (st_q.dpd),
        .ce_was_low (st_q.ce_low),
        .dpd_armed  (!rcr[ARM_BIT]),
        .cyc        (cyc)
    );

    psram_fe_cfg #(
        .BCR_RST (BCR_RST),
        .RCR_RST (RCR_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (dq_in),
        .restore (cfg_restore),
        .bcr     (bcr),
        .rcr     (rcr)
    );

    psram_fe_array #(
        .ADDR_W (ADDR_W)
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .lanes ({!ub_n, !lb_n}),
        .waddr (st_q.addr),
        .wdata (dq_in),
        .clr   (arr_clr),
        .raddr (st_q.addr),
        .rdata (arr_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.oe_lo    = 1'b0;
        st_d.oe_hi    = 1'b0;
        st_d.wait_act = 1'b0;
        st_d.ce_low   = !ce_n;
        st_d.cyc      = cyc;
        st_d.wait_oe  = (cyc != CT_STANDBY) && (cyc != CT_DPD);
        arr_we        = 1'b0;
        arr_clr       = 1'b0;
        cfg_we        = 1'b0;
        cfg_sel       = st_q.addr[0];
        cfg_restore   = 1'b0;

        unique case (cyc)
            CT_DPD: begin
                if (st_q.dpd) begin
                    if (!ce_n) begin
                        st_d.dpd    = 1'b0;
                        cfg_restore = 1'b1;
                    end
                end else begin
                    st_d.dpd = 1'b1;
                    st_d.bst = BS_IDLE;
                    arr_clr  = 1'b1;
                end
            end
            CT_STANDBY: st_d.bst = BS_IDLE;
            CT_NOP: ;
            CT_ADDR: begin
                st_d.addr = dq_in[ADDR_W-1:0];
                st_d.bst  = BS_IDLE;
            end
            CT_READ: begin
                st_d.dout  = arr_rdata;
                st_d.oe_lo = !lb_n;
                st_d.oe_hi = !ub_n;
            end
            CT_WRITE: arr_we = 1'b1;
            CT_CFG_WR: begin
                if (burst_mode && !adv_n) begin
                    st_d.sel = dq_in[0];
                    st_d.bst = BS_CFG_WR;
                end else begin
                    cfg_we = 1'b1;
                end
            end
            CT_CFG_RD: begin
                if (burst_mode && !adv_n) begin
                    st_d.sel = dq_in[0];
                    st_d.bst = BS_CFG_RD;
                end else begin
                    st_d.dout  = st_q.addr[0] ? bcr : rcr;
                    st_d.oe_lo = !lb_n;
                    st_d.oe_hi = !ub_n;
                end
            end
            CT_BRD_INIT, CT_BWR_INIT: begin
                st_d.addr     = dq_in[ADDR_W-1:0];
                st_d.bst      = (cyc == CT_BRD_INIT) ? BS_RD : BS_WR;
                st_d.wait_act = 1'b1;
            end
            CT_BCONT: begin
                unique case (st_q.bst)
                    BS_RD: begin
                        st_d.dout  = arr_rdata;
                        st_d.oe_lo = !oe_n && !lb_n;
                        st_d.oe_hi = !oe_n && !ub_n;
                        st_d.addr  = st_q.addr + 1'b1;
                    end
                    BS_WR: begin
                        arr_we    = 1'b1;
                        st_d.addr = st_q.addr + 1'b1;
                    end
                    BS_CFG_WR: begin
                        cfg_we   = 1'b1;
                        cfg_sel  = st_q.sel;
                        st_d.bst = BS_IDLE;
                    end
                    BS_CFG_RD: begin
                        st_d.dout  = st_q.sel ? bcr : rcr;
                        st_d.oe_lo = !oe_n && !lb_n;
                        st_d.oe_hi = !oe_n && !ub_n;
                        st_d.bst   = BS_IDLE;
                    end
                    default: st_d.bst = BS_IDLE;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr     <= '0;
            st_q.bst      <= BS_IDLE;
            st_q.sel      <= 1'b0;
            st_q.dpd      <= 1'b0;
            st_q.ce_low   <= 1'b0;
            st_q.dout     <= '0;
            st_q.oe_lo    <= 1'b0;
            st_q.oe_hi    <= 1'b0;
            st_q.wait_act <= 1'b0;
            st_q.wait_oe  <= 1'b0;
            st_q.cyc      <= CT_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out   = st_q.dout;
    assign dq_oe_lo = st_q.oe_lo;
    assign dq_oe_hi = st_q.oe_hi;
    assign wait_o   = st_q.wait_act ? bcr[WPOL_BIT] : !bcr[WPOL_BIT];
    assign wait_oe  = st_q.wait_oe;
    assign cycle    = st_q.cyc;
    assign dpd      = st_q.dpd;

endmodule

// File: rtl/mux_psram_fe_chk.sv
`timescale 1ns/1ps
module mux_psram_fe_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic lb_n,
    input logic ub_n,
    input logic dq_oe_lo,
    input logic dq_oe_hi,
    input logic wait_oe,
    input logic dpd
);

    // R9: a deselected cycle leaves the bus and WAIT undriven afterwards
    a_r9_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dq_oe_lo && !dq_oe_hi && !wait_oe));

    // R11: nothing is driven while powered down
    a_r11_dpd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dpd |-> (!dq_oe_lo && !dq_oe_hi && !wait_oe));

    // R11: a chip-enable fall leaves power-down
    a_r11_dpd_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (dpd && !ce_n) |=> !dpd);

    // R4: each lane is driven only if its select was low
    a_r4_lane_lo: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_lo |-> $past(!lb_n));

    a_r4_lane_hi: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_hi |-> $past(!ub_n));

endmodule

bind mux_psram_fe mux_psram_fe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .lb_n     (lb_n),
    .ub_n     (ub_n),
    .dq_oe_lo (dq_oe_lo),
    .dq_oe_hi (dq_oe_hi),
    .wait_oe  (wait_oe),
    .dpd      (dpd)
);

// File: tb/tb_mux_psram_fe.sv
`timescale 1ns/1ps
module tb_mux_psram_fe;

    // cycle codes as listed in R2
    localparam logic [3:0] C_SB = 4'd0, C_NOP = 4'd1, C_RD = 4'd2, C_WR = 4'd3,
                           C_BR = 4'd4, C_BW = 4'd5, C_BC = 4'd6, C_CW = 4'd7,
                           C_CR = 4'd8, C_DPD = 4'd9, C_AD = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic        cre = 1'b0, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0] dq_in = 16'h0;
    logic [15:0] dq_out;
    logic        dq_oe_lo, dq_oe_hi, wait_o, wait_oe, dpd;
    logic [3:0]  cycle;

    always #2.5 clk = ~clk;

    mux_psram_fe dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
        .we_n(we_n), .cre(cre), .lb_n(lb_n), .ub_n(ub_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
        .wait_o(wait_o), .wait_oe(wait_oe), .cycle(cycle), .dpd(dpd)
    );

    typedef struct {
        string       req;
        logic [3:0]  code;
        bit          cd;
        logic [15:0] d;
        logic        lo;
        logic        hi;
        bit          cw;
        logic        w;
        logic        dp;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   exp_dpd = 1'b0;
    bit   done = 1'b0;

    task automatic drv(input bit ce, adv, oe, we, cr, lb, ub,
                       input logic [15:0] dq, input string r, input logic [3:0] code,
                       input bit cd = 0, input logic [15:0] d = 16'h0,
                       input bit lo = 0, input bit hi = 0,
                       input bit cw = 0, input bit w = 0);
        exp_t e;
        @(negedge clk);
        ce_n = ce; adv_n = adv; oe_n = oe; we_n = we; cre = cr;
        lb_n = lb; ub_n = ub; dq_in = dq;
        e.req = r; e.code = code; e.cd = cd; e.d = d; e.lo = lo; e.hi = hi;
        e.cw = cw; e.w = w; e.dp = exp_dpd;
        sb.push_back(e);
    endtask

    function automatic bit chk(input string r, input string what,
                               input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
            return 1'b1;
        end
        return 1'b0;
    endfunction

    // monitor: pops one expectation per clock once the outputs have settled
    initial begin
        exp_t e;
        bit   bad;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e   = sb.pop_front();
                bad = 1'b0;
                n_vec++;
                bad |= chk({"R2 ", e.req}, "cycle", {12'h0, cycle}, {12'h0, e.code});
                bad |= chk({"R4 ", e.req}, "oe_lo", {15'h0, dq_oe_lo}, {15'h0, e.lo});
                bad |= chk({"R4 ", e.req}, "oe_hi", {15'h0, dq_oe_hi}, {15'h0, e.hi});
                bad |= chk({"R8 ", e.req}, "wait_oe", {15'h0, wait_oe},
                           {15'h0, !(e.code == C_SB || e.code == C_DPD)});
                bad |= chk({"R11 ", e.req}, "dpd", {15'h0, dpd}, {15'h0, e.dp});
                if (e.cd) bad |= chk(e.req, "dq_out", dq_out, e.d);
                if (e.cw) bad |= chk({"R8 ", e.req}, "wait", {15'h0, wait_o}, {15'h0, e.w});
                if (bad) n_bad++;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        n_vec++;
        if (cycle !== C_SB || dq_oe_lo !== 1'b0 || dq_oe_hi !== 1'b0 ||
            wait_oe !== 1'b0 || dpd !== 1'b0) begin
            $display("FAIL R1 reset outputs: actual cyc=%0d lo=%b hi=%b woe=%b dpd=%b expected 0 0 0 0 0",
                     cycle, dq_oe_lo, dq_oe_hi, wait_oe, dpd);
            n_bad++;
        end
        rst_n = 1'b1;

        // R3 asynchronous latch, write, read
        drv(0,0,1,1,0,0,0,16'h0003,"R3 latch",C_AD);
        drv(0,1,1,0,0,0,0,16'hA5C3,"R3 write",C_WR);
        drv(0,1,1,1,0,0,0,16'h0000,"R10 nop",C_NOP);
        drv(0,1,0,1,0,0,0,16'h0000,"R3 read",C_RD,1,16'hA5C3,1,1);
        // R4 byte lanes
        drv(0,0,1,1,0,0,0,16'h0005,"R4 latch",C_AD);
        drv(0,1,1,0,0,0,0,16'hABCD,"R4 full write",C_WR);
        drv(0,1,1,0,0,0,1,16'h1234,"R4 low-lane write",C_WR);
        drv(0,1,0,1,0,1,0,16'h0000,"R4 high-lane read",C_RD,1,16'hAB34,0,1);
        // R9 standby ignores inputs; R11 arm bit still set, so no power-down
        drv(1,1,1,0,0,0,0,16'hFFFF,"R9 standby write",C_SB);
        drv(1,0,1,0,0,0,0,16'h0007,"R9 standby latch",C_SB);
        drv(0,1,0,1,0,0,0,16'h0000,"R9 read after standby",C_RD,1,16'hAB34,1,1);
        // R5 configuration access, asynchronous
        drv(0,0,1,1,0,0,0,16'h0001,"R5 select bcr",C_AD);
        drv(0,1,0,1,1,0,0,16'h0000,"R5 bcr read",C_CR,1,16'h8400,1,1);
        drv(0,1,1,0,1,0,0,16'h8000,"R5 bcr write",C_CW);
        drv(0,1,1,1,0,0,0,16'h0000,"R8 active-low idle",C_NOP,0,0,0,0,1,1);
        drv(0,1,0,1,1,0,0,16'h0000,"R5 bcr readback",C_CR,1,16'h8000,1,1);
        drv(0,1,1,0,1,0,0,16'h0400,"R6 enter burst",C_CW);
        drv(0,1,1,1,0,0,0,16'h0000,"R8 active-high idle",C_NOP,0,0,0,0,1,0);
        // R6 burst write then read
        drv(0,0,1,0,0,0,0,16'h0008,"R6 burst write start",C_BW,0,0,0,0,1,1);
        drv(0,1,1,1,0,0,0,16'h1111,"R6 continue w0",C_BC,0,0,0,0,1,0);
        drv(0,1,1,1,0,0,0,16'h2222,"R6 continue w1",C_BC);
        drv(0,1,1,1,0,0,0,16'h3333,"R6 continue w2",C_BC);
        drv(1,1,1,1,0,1,1,16'h0000,"R9 end burst",C_SB);
        drv(0,0,1,1,0,0,0,16'h0008,"R6 burst read start",C_BR,0,0,0,0,1,1);
        drv(0,1,0,1,0,0,0,16'h0000,"R6 continue r0",C_BC,1,16'h1111,1,1,1,0);
        drv(0,1,0,1,0,0,0,16'h0000,"R6 continue r1",C_BC,1,16'h2222,1,1);
        drv(0,1,0,1,0,0,0,16'h0000,"R6 continue r2",C_BC,1,16'h3333,1,1);
        drv(1,1,1,1,0,1,1,16'h0000,"R9 end burst",C_SB);
        // R7 burst-mode configuration accesses
        drv(0,0,0,1,1,0,0,16'h0000,"R7 cfg read start",C_CR);
        drv(0,1,0,1,0,0,0,16'h0000,"R7 cfg read word",C_BC,1,16'h0010,1,1);
        drv(0,1,1,1,0,0,0,16'h0000,"R7 burst ended",C_NOP);
        drv(0,0,1,0,1,0,0,16'h0000,"R7 cfg write start",C_CW);
        drv(0,1,1,1,0,0,0,16'h0000,"R7 cfg write word",C_BC);
        // R11 deep power-down
        exp_dpd = 1'b1;
        drv(1,1,1,1,0,1,1,16'h0000,"R11 enter",C_DPD);
        drv(1,0,0,1,1,0,0,16'h0001,"R11 hold",C_DPD);
        exp_dpd = 1'b0;
        drv(0,1,1,0,0,0,0,16'h5A5A,"R11 exit",C_DPD);
        drv(0,0,1,1,0,0,0,16'h0003,"R11 latch",C_AD);
        drv(0,1,0,1,0,0,0,16'h0000,"R11 wiped word",C_RD,1,16'h0000,1,1);
        drv(0,0,1,1,0,0,0,16'h0001,"R11 select bcr",C_AD);
        drv(0,1,0,1,1,0,0,16'h0000,"R11 bcr restored",C_CR,1,16'h8400,1,1);
        drv(0,0,1,1,0,0,0,16'h0000,"R11 select rcr",C_AD);
        drv(0,1,0,1,1,0,0,16'h0000,"R11 rcr restored",C_CR,1,16'h0010,1,1);
        drv(1,1,1,1,0,1,1,16'h0000,"R9 final standby",C_SB);

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule